// File: doc/BRIEF.md
# Vehicle Operating-Mode Controller

This block decides the operating mode of an electric vehicle drive and gates the motor controllers. After reset it sits in a self-test mode. An external test sequencer reports the outcome with a one-cycle done strobe and a pass level. A passing result moves the block to an idle mode, where it waits for the driver's start key. From then on the block alternates between running and stopped, following the level of the start key.

Any protection flag takes the block to a fault mode at once, whatever mode it is in. Only a reset clears the fault mode. The start key and the direction switch come from mechanical contacts, so each one passes through a synchronizer and a debouncer before it is used. The debouncer samples on a tick that an internal prescaler produces. It accepts a new level only after that level has held for a run-time programmable number of consecutive ticks. The motor enable is high only in the running mode.

Top module: `ev_mode_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `mode` is 0 (self-test), `motor_en` is 0 and `dir_db` is 0.
- R2: In self-test (0), a cycle with `test_done`=1 and `test_pass`=1 and no fault gives `mode`=1 (idle) on the next clock edge.
- R3: In self-test, a cycle with `test_done`=1 and `test_pass`=0 gives `mode`=4 (fault) on the next clock edge. Without `test_done` the block stays in self-test, whatever the start key does.
- R4: In idle, the mode changes only to 2 (run), when the debounced start key is 1, or to 4 (fault).
- R5: After leaving idle, the mode is 2 (run) while the debounced start key is 1 and 3 (stop) while it is 0.
- R6: Any bit of `fault_flags` set on a clock edge gives `mode`=4 on that edge, from every mode, ahead of every other transition.
- R7: Once the mode is 4 (fault), it stays 4 until reset, whatever the start, test or fault inputs do.
- R8: `motor_en` is 1 exactly when `mode` is 2 (run). It rises only when the mode comes from idle or stop.
- R9: The sample tick occurs every `TICK_DIV` clocks. A debounced input takes a new raw level only after that level has held for `db_ticks` consecutive ticks (a value of 0 counts as 1). A pulse shorter than that is ignored.
- R10: `dir_db` is the debounced copy of `dir_raw`, filtered the same way as the start key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_ticks | input | DBW | Ticks a new input level must hold before it is accepted |
| start_raw | input | 1 | Raw driver start key |
| dir_raw | input | 1 | Raw driver direction switch |
| test_done | input | 1 | Self-test finished strobe |
| test_pass | input | 1 | Self-test result, 1 = pass |
| fault_flags | input | NFAULT | Protection flags, any bit set means fault |
| mode | output | 3 | Mode: 0 test, 1 idle, 2 run, 3 stop, 4 fault |
| motor_en | output | 1 | Motor controller enable |
| dir_db | output | 1 | Debounced direction |

## Verification
The assertions assume that `fault_flags`, `test_done` and `test_pass` are already clean, synchronous levels, since none of them is filtered. They also assume that `db_ticks` does not change while a key is moving. The bench changes every input on the falling edge, sets `db_ticks` once after reset, and holds each key level far longer than one debounce window, except in the deliberate short-glitch tests.

// File: rtl/ev_mode_ctrl.sv
module ev_mode_ctrl #(
  parameter int NFAULT   = 4,
  parameter int DBW      = 8,
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DBW-1:0]    db_ticks,
  input  logic              start_raw,
  input  logic              dir_raw,
  input  logic              test_done,
  input  logic              test_pass,
  input  logic [NFAULT-1:0] fault_flags,
  output logic [2:0]        mode,
  output logic              motor_en,
  output logic              dir_db
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int NIN = 2;

  typedef enum logic [2:0] {
    M_TEST  = 3'd0,
    M_IDLE  = 3'd1,
    M_RUN   = 3'd2,
    M_STOP  = 3'd3,
    M_FAULT = 3'd4
  } mode_t;

  logic [TW-1:0]  tick_cnt;
  logic           tick;
  logic [DBW:0]   lim;
  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] filt;
  mode_t          st_q, st_d;

  assign tick   = (tick_cnt == TW'(TICK_DIV - 1));
  assign lim    = (db_ticks == '0) ? (DBW+1)'(1) : {1'b0, db_ticks};
  assign raw_in = {dir_raw, start_raw};

  always_ff @(posedge clk) begin
    if (!rst_n || tick) tick_cnt <= '0;
    else                tick_cnt <= tick_cnt + TW'(1);
  end

  for (genvar i = 0; i < NIN; i++) begin : g_db
    logic           s1, s2, stab;
    logic [DBW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        stab <= 1'b0;
        cnt  <= '0;
      end else begin
        s1 <= raw_in[i];
        s2 <= s1;
        if (tick) begin
          if (s2 != stab) begin
            if ({1'b0, cnt} + (DBW+1)'(1) >= lim) begin
              stab <= s2;
              cnt  <= '0;
            end else begin
              cnt <= cnt + DBW'(1);
            end
          end else begin
            cnt <= '0;
          end
        end
      end
    end
    assign filt[i] = stab;
  end

  always_comb begin
    st_d = st_q;
    if (|fault_flags) st_d = M_FAULT;
    else begin
      case (st_q)
        M_TEST:  if (test_done) st_d = test_pass ? M_IDLE : M_FAULT;
        M_IDLE:  if (filt[0]) st_d = M_RUN;
        M_RUN:   if (!filt[0]) st_d = M_STOP;
        M_STOP:  if (filt[0]) st_d = M_RUN;
        default: st_d = M_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= M_TEST;
    else        st_q <= st_d;
  end

  assign mode     = st_q;
  assign motor_en = (st_q == M_RUN);
  assign dir_db   = filt[1];
endmodule

// File: rtl/ev_mode_ctrl_chk.sv
module ev_mode_ctrl_chk #(
  parameter int NFAULT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              test_done,
  input logic              test_pass,
  input logic [NFAULT-1:0] fault_flags,
  input logic [2:0]        mode,
  input logic              motor_en
);
  // R6
  fault_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_flags) |=> (mode == 3'd4));

  // R7
  fault_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |=> (mode == 3'd4));

  // R2
  test_exit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && test_done && test_pass && !(|fault_flags)) |=> (mode == 3'd1));

  // R3
  test_exit_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && test_done && !test_pass) |=> (mode == 3'd4));

  // R4
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |=> (mode == 3'd1 || mode == 3'd2 || mode == 3'd4));

  // R8
  enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(motor_en) |-> ($past(mode) == 3'd1 || $past(mode) == 3'd3));
endmodule

bind ev_mode_ctrl ev_mode_ctrl_chk #(.NFAULT(NFAULT)) chk_i (
  .clk(clk), .rst_n(rst_n), .test_done(test_done), .test_pass(test_pass),
  .fault_flags(fault_flags), .mode(mode), .motor_en(motor_en)
);

// File: tb/ev_mode_ctrl_tb_top.sv
module ev_mode_ctrl_tb_top;
  localparam int PERIOD = 10;
  localparam int NF = 4;
  localparam int NV = 9;
  // fields: fault[18:15] start[14] dir[13] done[12] pass[11] hold[10:3] mode[2:0]
  localparam logic [18:0] VEC [NV] = '{
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5,  3'd0},
    {4'b0000, 1'b0, 1'b0, 1'b1, 1'b1, 8'd1,  3'd1},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd30, 3'd1},
    {4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'd30, 3'd2},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd30, 3'd3},
    {4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 8'd30, 3'd2},
    {4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 8'd30, 3'd3},
    {4'b0100, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1,  3'd4},
    {4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 8'd30, 3'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] db_ticks = 8'd3;
  logic start_raw = 1'b0, dir_raw = 1'b0, test_done = 1'b0, test_pass = 1'b0;
  logic [NF-1:0] fault_flags = '0;
  logic [2:0] mode;
  logic motor_en, dir_db;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  ev_mode_ctrl #(.NFAULT(NF), .DBW(8), .TICK_DIV(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .db_ticks(db_ticks), .start_raw(start_raw),
    .dir_raw(dir_raw), .test_done(test_done), .test_pass(test_pass),
    .fault_flags(fault_flags), .mode(mode), .motor_en(motor_en), .dir_db(dir_db)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start_raw = 0; dir_raw = 0; test_done = 0; test_pass = 0; fault_flags = '0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic pass_tests();
    test_done = 1; test_pass = 1; cyc(1); test_done = 0; test_pass = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(2);
    chk("R1 mode in reset", 8'(mode), 8'd0);
    chk("R1 enable in reset", 8'(motor_en), 8'd0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 mode after reset", 8'(mode), 8'd0);
    chk("R1 dir after reset", 8'(dir_db), 8'd0);

    for (int v = 0; v < NV; v++) begin
      fault_flags = VEC[v][18:15];
      start_raw   = VEC[v][14];
      dir_raw     = VEC[v][13];
      test_done   = VEC[v][12];
      test_pass   = VEC[v][11];
      cyc(int'(VEC[v][10:3]));
      chk($sformatf("R5 R6 R7 vector %0d mode", v), 8'(mode), 8'(VEC[v][2:0]));
      chk($sformatf("R8 vector %0d enable", v), 8'(motor_en), 8'(VEC[v][2:0] == 3'd2));
    end

    // R3: failing self-test, and start ignored in self-test
    do_reset();
    start_raw = 1; cyc(30);
    chk("R3 start ignored in test", 8'(mode), 8'd0);
    test_done = 1; test_pass = 0; cyc(1); test_done = 0;
    chk("R3 failed test goes to fault", 8'(mode), 8'd4);
    rst_n = 0; cyc(1); rst_n = 1; start_raw = 0; cyc(1);
    chk("R7 reset clears fault", 8'(mode), 8'd0);

    // R6: fault in self-test wins over a passing strobe
    do_reset();
    cyc(2);
    fault_flags = 4'b0001; test_done = 1; test_pass = 1; cyc(1);
    fault_flags = '0; test_done = 0;
    chk("R6 fault beats test pass", 8'(mode), 8'd4);

    // R9: glitch rejected, early level not accepted
    do_reset();
    pass_tests();
    chk("R2 passing test to idle", 8'(mode), 8'd1);
    start_raw = 1; cyc(6); start_raw = 0; cyc(30);
    chk("R9 short start pulse ignored", 8'(mode), 8'd1);
    start_raw = 1; cyc(6);
    chk("R9 start not accepted early", 8'(mode), 8'd1);
    cyc(24);
    chk("R4 debounced start enters run", 8'(mode), 8'd2);
    chk("R8 enable in run", 8'(motor_en), 8'd1);
    start_raw = 0; cyc(5); start_raw = 1; cyc(30);
    chk("R9 short drop keeps run", 8'(mode), 8'd2);

    // R6/R7: fault from run, held with start high
    fault_flags = 4'b1000; cyc(1); fault_flags = '0;
    chk("R6 fault from run", 8'(mode), 8'd4);
    chk("R8 enable low in fault", 8'(motor_en), 8'd0);
    test_done = 1; test_pass = 1; start_raw = 0; cyc(40); test_done = 0;
    chk("R7 fault stays latched", 8'(mode), 8'd4);

    // R10: direction debounce
    do_reset();
    dir_raw = 1; cyc(5);
    chk("R10 dir not accepted early", 8'(dir_db), 8'd0);
    cyc(25);
    chk("R10 dir accepted", 8'(dir_db), 8'd1);
    dir_raw = 0; cyc(5); dir_raw = 1; cyc(30);
    chk("R10 dir glitch ignored", 8'(dir_db), 8'd1);

    // R9: db_ticks of zero acts as one tick
    do_reset();
    db_ticks = 8'd0;
    dir_raw = 1; cyc(10);
    chk("R9 zero threshold as one", 8'(dir_db), 8'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule